// File: doc/BRIEF.md
# Transmit descriptor chain gatherer

This block fetches transmit work from a chain of descriptors kept in system memory. Each descriptor occupies four consecutive 32-bit words and points to one buffer plus the next descriptor. The block reads the descriptors over a simple 32-bit request/acknowledge memory port and copies each buffer into a local 2048-byte frame store. It then writes the descriptor back with its ownership bit cleared, so software gets it back. A descriptor flagged as the final piece of a frame makes the block stream the gathered bytes out on a byte-wide valid/ready interface, together with a flag saying whether checksum insertion was asked for.

Software loads the list base and then writes the control word with the enable bit set. The walk runs until it meets a descriptor that hardware does not own, or until a frame would not fit in the store. If at least one frame left the block during the walk, a sticky done status is raised and the start bit is dropped.

Top module: `tx_desc_gather`

## Requirements
- R1: After reset the block is idle (busy 0), issues no memory request, shows out_valid 0, and has done_sts 0, dma_start 0 and cur_ptr 0.
- R2: A base_wr pulse while idle loads cur_ptr with base_addr and starts nothing. A ctl_wr pulse while idle stores ctl_start into dma_start, and when ctl_dma_en is 1 it starts a walk at cur_ptr.
- R3: A descriptor at address A is read as status (A), status2 (A+4), buffer address (A+8) and next address (A+12). Hardware owns it when status bit 31 is 1. The walk ends at the first descriptor it does not own, leaves cur_ptr pointing at that descriptor, and writes nothing back to it.
- R4: The buffer length is status2 bits 10:0. The buffer address is word aligned, and inside each 32-bit word the byte at the lowest address sits in bits 7:0.
- R5: After a buffer is copied, the descriptor's status word is written back to A with bit 31 cleared and all other bits unchanged.
- R6: A frame leaves the block only after a descriptor whose status2 bit 30 is 1. It is made of the buffers of its descriptors joined in chain order, and out_last is 1 on its final byte only. The gathered length then restarts at zero, so the next frame carries only its own bytes.
- R7: out_csum is 1 for the whole frame when status2 bits 28:27 of the frame's final descriptor are nonzero, and 0 when they are zero.
- R8: If the bytes already gathered plus the current buffer length exceed 2048, the status word is written back with bit 14 set and bit 31 left as read. The walk then ends with cur_ptr on that descriptor, and the partial frame is never output.
- R9: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold their values.
- R10: When a walk ends after at least one frame was output, done_sts becomes 1 and dma_start becomes 0. A walk that outputs no frame leaves both unchanged.
- R11: A sts_clr pulse clears done_sts. If the clear and the end of a frame-sending walk fall in the same cycle, done_sts ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_wr | input | 1 | Load list base (idle only) |
| base_addr | input | 32 | Descriptor list base address |
| ctl_wr | input | 1 | Control word write strobe (idle only) |
| ctl_start | input | 1 | Start bit value written with ctl_wr |
| ctl_dma_en | input | 1 | Enable bit; 1 with ctl_wr starts a walk |
| sts_clr | input | 1 | Clears the done status |
| busy | output | 1 | A walk is in progress |
| cur_ptr | output | 32 | Current descriptor address |
| dma_start | output | 1 | Stored start bit |
| done_sts | output | 1 | Sticky transmit-done status |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completes this cycle |
| out_valid | output | 1 | Frame byte valid |
| out_ready | input | 1 | Sink accepts a byte |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of the frame |
| out_csum | output | 1 | Checksum insertion requested for this frame |

## Verification
A software clear of the done status can land in the same cycle that a walk ends after sending a frame, and the set must win. The bench provokes this by holding sts_clr high for the whole of a frame-sending walk and releasing it on the first falling edge after busy drops. done_sts must then read 1, and a later lone clear must bring it to 0. A second overlap arises inside one walk, where a frame end resets the gathered length while the next descriptor is already being fetched. It is judged by two back-to-back frames that must each carry only their own bytes, each with its own final-byte marker and checksum flag.

// File: rtl/tx_gather_pkg.sv
package tx_gather_pkg;
  localparam int OWN_BIT     = 31;
  localparam int LAST_BIT    = 30;
  localparam int LEN_ERR_BIT = 14;
  localparam int CS_HI       = 28;
  localparam int CS_LO       = 27;
  localparam int CNT_W       = 11;

  typedef enum logic [3:0] {
    W_IDLE, W_ST0, W_ST1, W_BUF, W_NXT, W_COPY, W_WB, W_ERR, W_EMIT
  } walk_t;
endpackage

// File: rtl/tx_frame_buf.sv
module tx_frame_buf #(
  parameter int BUF_BYTES = 2048,
  parameter int IDX_W     = 11,
  parameter int LEN_W     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_base,
  input  logic [3:0]       wr_mask,
  input  logic [31:0]      wr_word,
  input  logic             go,
  input  logic [LEN_W-1:0] go_len,
  input  logic             go_csum,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic             out_csum,
  output logic             done
);
  logic [7:0]       store_q [BUF_BYTES];
  logic             act_q, act_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             cs_q, cs_d;
  logic             last;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int l = 0; l < 4; l++) begin
        if (wr_mask[l]) store_q[wr_base + IDX_W'(l)] <= wr_word[8*l +: 8];
      end
    end
  end

  assign last = act_q && (LEN_W'(idx_q) == len_q - LEN_W'(1));
  assign done = act_q && out_ready && last;

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    len_d = len_q;
    cs_d  = cs_q;
    if (go) begin
      act_d = 1'b1;
      idx_d = '0;
      len_d = go_len;
      cs_d  = go_csum;
    end else if (act_q && out_ready) begin
      if (last) act_d = 1'b0;
      else      idx_d = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
      len_q <= '0;
      cs_q  <= 1'b0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
      len_q <= len_d;
      cs_q  <= cs_d;
    end
  end

  assign out_valid = act_q;
  assign out_data  = store_q[idx_q];
  assign out_last  = last;
  assign out_csum  = cs_q;

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R6
  last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);
endmodule

// File: rtl/tx_walk_ctl.sv
module tx_walk_ctl
  import tx_gather_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int IDX_W     = 11,
  parameter int LEN_W     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_wr,
  input  logic [31:0]      base_addr,
  input  logic             ctl_wr,
  input  logic             ctl_start,
  input  logic             ctl_dma_en,
  input  logic             sts_clr,
  output logic             busy,
  output logic [31:0]      cur_ptr,
  output logic             dma_start,
  output logic             done_sts,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_ack,
  output logic             buf_wr,
  output logic [IDX_W-1:0] buf_base,
  output logic [3:0]       buf_mask,
  output logic [31:0]      buf_word,
  output logic             emit_go,
  output logic [LEN_W-1:0] emit_len,
  output logic             emit_csum,
  input  logic             emit_done
);
  localparam int WC_W = LEN_W - 2;

  walk_t            st_q, st_d;
  logic [31:0]      cur_q, cur_d, s0_q, s0_d, s1_q, s1_d, ba_q, ba_d, nx_q, nx_d;
  logic [LEN_W-1:0] acc_q, acc_d;
  logic [WC_W-1:0]  wc_q, wc_d;
  logic             sent_q, sent_d, start_q, start_d, done_q, done_d;
  logic [LEN_W-1:0] cnt, off, total;
  logic             fin;

  assign cnt   = LEN_W'(s1_q[CNT_W-1:0]);
  assign off   = {wc_q, 2'b00};
  assign total = acc_q + cnt;
  assign fin   = ((st_q == W_ST0) && mem_ack && !mem_rdata[OWN_BIT]) ||
                 ((st_q == W_ERR) && mem_ack);

  // Memory port and buffer write lanes
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_q;
    mem_wdata = '0;
    case (st_q)
      W_ST0:  mem_req = 1'b1;
      W_ST1:  begin mem_req = 1'b1; mem_addr = cur_q + 32'd4;  end
      W_BUF:  begin mem_req = 1'b1; mem_addr = cur_q + 32'd8;  end
      W_NXT:  begin mem_req = 1'b1; mem_addr = cur_q + 32'd12; end
      W_COPY: begin mem_req = 1'b1; mem_addr = ba_q + 32'(off); end
      W_WB:   begin mem_req = 1'b1; mem_we = 1'b1;
                    mem_wdata = s0_q & ~(32'd1 << OWN_BIT); end
      W_ERR:  begin mem_req = 1'b1; mem_we = 1'b1;
                    mem_wdata = s0_q | (32'd1 << LEN_ERR_BIT); end
      default: ;
    endcase
    buf_wr   = (st_q == W_COPY) && mem_ack;
    buf_base = IDX_W'(acc_q + off);
    buf_word = mem_rdata;
    for (int l = 0; l < 4; l++) buf_mask[l] = (off + LEN_W'(l)) < cnt;
  end

  // Next-state logic
  always_comb begin
    st_d = st_q;  cur_d = cur_q;  s0_d = s0_q;  s1_d = s1_q;
    ba_d = ba_q;  nx_d = nx_q;    acc_d = acc_q; wc_d = wc_q;
    sent_d = sent_q; start_d = start_q; done_d = done_q;
    emit_go   = 1'b0;
    emit_len  = total;
    emit_csum = |s1_q[CS_HI:CS_LO];
    case (st_q)
      W_IDLE: begin
        if (base_wr) cur_d = base_addr;
        if (ctl_wr) begin
          start_d = ctl_start;
          if (ctl_dma_en) begin
            st_d   = W_ST0;
            acc_d  = '0;
            sent_d = 1'b0;
          end
        end
      end
      W_ST0: if (mem_ack) begin
        s0_d = mem_rdata;
        st_d = mem_rdata[OWN_BIT] ? W_ST1 : W_IDLE;
      end
      W_ST1: if (mem_ack) begin s1_d = mem_rdata; st_d = W_BUF; end
      W_BUF: if (mem_ack) begin ba_d = mem_rdata; st_d = W_NXT; end
      W_NXT: if (mem_ack) begin
        nx_d = mem_rdata;
        wc_d = '0;
        if (total > LEN_W'(BUF_BYTES)) st_d = W_ERR;
        else if (cnt == '0)            st_d = W_WB;
        else                           st_d = W_COPY;
      end
      W_COPY: if (mem_ack) begin
        if (off + LEN_W'(4) >= cnt) st_d = W_WB;
        else                        wc_d = wc_q + WC_W'(1);
      end
      W_WB: if (mem_ack) begin
        cur_d = nx_q;
        if (s1_q[LAST_BIT]) begin
          acc_d = '0;
          if (total != '0) begin
            emit_go = 1'b1;
            sent_d  = 1'b1;
            st_d    = W_EMIT;
          end else begin
            st_d = W_ST0;
          end
        end else begin
          acc_d = total;
          st_d  = W_ST0;
        end
      end
      W_ERR: if (mem_ack) begin acc_d = '0; st_d = W_IDLE; end
      W_EMIT: if (emit_done) st_d = W_ST0;
      default: st_d = W_IDLE;
    endcase
    if (sts_clr) done_d = 1'b0;
    if (fin && sent_q) begin
      done_d  = 1'b1;
      start_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= W_IDLE;  cur_q <= '0;  s0_q <= '0;  s1_q <= '0;
      ba_q <= '0;      nx_q <= '0;   acc_q <= '0; wc_q <= '0;
      sent_q <= 1'b0;  start_q <= 1'b0; done_q <= 1'b0;
    end else begin
      st_q <= st_d;    cur_q <= cur_d; s0_q <= s0_d; s1_q <= s1_d;
      ba_q <= ba_d;    nx_q <= nx_d;   acc_q <= acc_d; wc_q <= wc_d;
      sent_q <= sent_d; start_q <= start_d; done_q <= done_d;
    end
  end

  assign busy      = (st_q != W_IDLE);
  assign cur_ptr   = cur_q;
  assign dma_start = start_q;
  assign done_sts  = done_q;

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= LEN_W'(BUF_BYTES));

  // R10
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(start_q) && !$past(ctl_wr)) |-> done_q);

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && sent_q) |=> done_q);

  // R3
  stop_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mem_req && mem_ack));
endmodule

// File: rtl/tx_desc_gather.sv
module tx_desc_gather #(
  parameter int BUF_BYTES = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        base_wr,
  input  logic [31:0] base_addr,
  input  logic        ctl_wr,
  input  logic        ctl_start,
  input  logic        ctl_dma_en,
  input  logic        sts_clr,
  output logic        busy,
  output logic [31:0] cur_ptr,
  output logic        dma_start,
  output logic        done_sts,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_last,
  output logic        out_csum
);
  localparam int IDX_W = $clog2(BUF_BYTES);
  localparam int LEN_W = ((IDX_W > tx_gather_pkg::CNT_W) ? IDX_W : tx_gather_pkg::CNT_W) + 1;

  logic             buf_wr, emit_go, emit_csum, emit_done;
  logic [IDX_W-1:0] buf_base;
  logic [3:0]       buf_mask;
  logic [31:0]      buf_word;
  logic [LEN_W-1:0] emit_len;

  tx_walk_ctl #(.BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .base_wr(base_wr), .base_addr(base_addr),
    .ctl_wr(ctl_wr), .ctl_start(ctl_start), .ctl_dma_en(ctl_dma_en),
    .sts_clr(sts_clr),
    .busy(busy), .cur_ptr(cur_ptr), .dma_start(dma_start), .done_sts(done_sts),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .buf_wr(buf_wr), .buf_base(buf_base), .buf_mask(buf_mask), .buf_word(buf_word),
    .emit_go(emit_go), .emit_len(emit_len), .emit_csum(emit_csum),
    .emit_done(emit_done)
  );

  tx_frame_buf #(.BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_fbuf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(buf_wr), .wr_base(buf_base), .wr_mask(buf_mask), .wr_word(buf_word),
    .go(emit_go), .go_len(emit_len), .go_csum(emit_csum),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_csum(out_csum), .done(emit_done)
  );
endmodule

// File: tb/tx_desc_gather_tb.sv
module tx_desc_gather_tb;
  localparam int CLK_P = 10;
  localparam int WDOG  = 150000;
  localparam logic [31:0] OWN  = 32'h8000_0000;
  localparam logic [31:0] LAST = 32'h4000_0000;
  localparam logic [31:0] ERRB = 32'h0000_4000;

  logic clk = 1'b0;
  logic rst_n;
  logic base_wr, ctl_wr, ctl_start, ctl_dma_en, sts_clr, out_ready;
  logic [31:0] base_addr, mem_addr, mem_wdata, mem_rdata, cur_ptr;
  logic busy, dma_start, done_sts, mem_req, mem_we, mem_ack;
  logic out_valid, out_last, out_csum;
  logic [7:0] out_data;

  logic [31:0] mem [0:4095];
  logic [7:0]  cap  [0:4095];
  logic        capl [0:4095];
  logic        capc [0:4095];
  int cap_n = 0, nchk = 0, nfail = 0, cyc = 0, stall_err = 0, rcnt = 0;
  bit stall_en = 1'b0;
  logic pv_valid = 1'b0, pv_ready = 1'b0, pv_last = 1'b0;
  logic [7:0] pv_data = 8'h00;

  always #(CLK_P/2) clk = ~clk;

  tx_desc_gather u_dut (
    .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_addr(base_addr),
    .ctl_wr(ctl_wr), .ctl_start(ctl_start), .ctl_dma_en(ctl_dma_en),
    .sts_clr(sts_clr), .busy(busy), .cur_ptr(cur_ptr), .dma_start(dma_start),
    .done_sts(done_sts), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_csum(out_csum)
  );

  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[13:2]];
  always @(posedge clk) if (mem_req && mem_we) mem[mem_addr[13:2]] <= mem_wdata;

  always @(posedge clk) begin
    rcnt <= rcnt + 1;
    out_ready <= stall_en ? ((rcnt % 3) != 0) : 1'b1;
  end

  always @(negedge clk) begin
    if (out_valid && out_ready && cap_n < 4096) begin
      cap[cap_n]  = out_data;
      capl[cap_n] = out_last;
      capc[cap_n] = out_csum;
      cap_n = cap_n + 1;
    end
    if (pv_valid && !pv_ready && !(out_valid && out_data == pv_data && out_last == pv_last))
      stall_err = stall_err + 1;
    pv_valid = out_valid; pv_ready = out_ready; pv_data = out_data; pv_last = out_last;
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 13) ^ (a >> 7));
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr_desc(input int a, input logic [31:0] s0, input logic [31:0] s1,
                         input logic [31:0] b, input logic [31:0] n);
    mem[a >> 2] = s0; mem[(a >> 2) + 1] = s1;
    mem[(a >> 2) + 2] = b; mem[(a >> 2) + 3] = n;
  endtask

  task automatic run_walk(input int base, input bit hold_clr);
    cap_n = 0;
    @(negedge clk); base_wr = 1'b1; base_addr = base;
    @(negedge clk); base_wr = 1'b0; ctl_wr = 1'b1; ctl_start = 1'b1; ctl_dma_en = 1'b1;
    sts_clr = hold_clr;
    @(negedge clk); ctl_wr = 1'b0;
    while (busy) @(negedge clk);
    sts_clr = 1'b0;
  endtask

  task automatic chk_bytes(input int at, input int addr, input int n, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) if (cap[at + i] !== pat(addr + i)) bad++;
    chk(bad == 0, tag, "byte mismatches", bad, 0);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0 && mem_req == 1'b0 && out_valid == 1'b0, "R1", "idle outputs",
        {busy, mem_req, out_valid}, 0);
    chk(done_sts == 1'b0 && dma_start == 1'b0 && cur_ptr == 0, "R1", "status/ptr",
        {done_sts, dma_start, cur_ptr}, 0);
    @(negedge clk); base_wr = 1'b1; base_addr = 32'h0000_0100;
    @(negedge clk); base_wr = 1'b0;
    @(negedge clk);
    chk(cur_ptr == 32'h100 && !busy, "R2", "base load only", cur_ptr, 32'h100);
  endtask

  task automatic t_single();
    wr_desc(32'h100, OWN | 32'h0000_00A5, LAST | 32'd5, 32'h1000, 32'h110);
    wr_desc(32'h110, 32'h0, 32'h0, 32'h0, 32'h0);
    run_walk(32'h100, 1'b0);
    chk(cap_n == 5, "R6", "frame length", cap_n, 5);
    chk_bytes(0, 32'h1000, 5, "R4");
    chk(capl[4] == 1'b1 && capl[3] == 1'b0 && capl[0] == 1'b0, "R6", "last marker",
        {capl[0], capl[3], capl[4]}, 1);
    chk(capc[0] == 1'b0, "R7", "csum off", capc[0], 0);
    chk(mem[32'h100 >> 2] == 32'h0000_00A5, "R5", "writeback", mem[32'h100 >> 2], 32'hA5);
    chk(cur_ptr == 32'h110 && mem[32'h110 >> 2] == 0, "R3", "stop at unowned", cur_ptr, 32'h110);
    chk(done_sts == 1'b1 && dma_start == 1'b0, "R10", "done/start", {done_sts, dma_start}, 2);
  endtask

  task automatic t_gather_stall();
    wr_desc(32'h200, OWN, 32'd3, 32'h1100, 32'h210);
    wr_desc(32'h210, OWN, LAST | 32'h0800_0000 | 32'd6, 32'h1200, 32'h220);
    wr_desc(32'h220, 32'h0, 32'h0, 32'h0, 32'h0);
    stall_err = 0; stall_en = 1'b1;
    run_walk(32'h200, 1'b0);
    stall_en = 1'b0;
    chk(cap_n == 9, "R6", "joined length", cap_n, 9);
    chk_bytes(0, 32'h1100, 3, "R6");
    chk_bytes(3, 32'h1200, 6, "R6");
    chk(capc[0] == 1'b1 && capc[8] == 1'b1, "R7", "csum on", {capc[0], capc[8]}, 3);
    chk(stall_err == 0, "R9", "stall hold", stall_err, 0);
    chk(mem[32'h200 >> 2] == 0 && mem[32'h210 >> 2] == 0, "R5", "both written back",
        mem[32'h210 >> 2], 0);
  endtask

  task automatic t_overflow();
    @(negedge clk); sts_clr = 1'b1;
    @(negedge clk); sts_clr = 1'b0;
    chk(done_sts == 1'b0, "R11", "clear pulse", done_sts, 0);
    wr_desc(32'h300, OWN, 32'd2000, 32'h2000, 32'h310);
    wr_desc(32'h310, OWN, LAST | 32'd100, 32'h3000, 32'h320);
    wr_desc(32'h320, 32'h0, 32'h0, 32'h0, 32'h0);
    run_walk(32'h300, 1'b0);
    chk(cap_n == 0, "R8", "no output", cap_n, 0);
    chk(mem[32'h310 >> 2] == (OWN | ERRB), "R8", "error flag", mem[32'h310 >> 2], OWN | ERRB);
    chk(mem[32'h300 >> 2] == 0, "R5", "first piece returned", mem[32'h300 >> 2], 0);
    chk(cur_ptr == 32'h310, "R8", "ptr at failing desc", cur_ptr, 32'h310);
    chk(done_sts == 1'b0 && dma_start == 1'b1, "R10", "unchanged", {done_sts, dma_start}, 1);
  endtask

  task automatic t_unowned();
    wr_desc(32'h400, 32'h0000_0033, LAST | 32'd4, 32'h1000, 32'h410);
    run_walk(32'h400, 1'b0);
    chk(cap_n == 0 && cur_ptr == 32'h400, "R3", "unowned head", cur_ptr, 32'h400);
    chk(mem[32'h400 >> 2] == 32'h33, "R3", "no writeback", mem[32'h400 >> 2], 32'h33);
    chk(done_sts == 1'b0 && dma_start == 1'b1, "R10", "no frame", {done_sts, dma_start}, 1);
  endtask

  task automatic t_set_vs_clear();
    wr_desc(32'h500, OWN, LAST | 32'd4, 32'h1000, 32'h510);
    wr_desc(32'h510, 32'h0, 32'h0, 32'h0, 32'h0);
    run_walk(32'h500, 1'b1);
    chk(done_sts == 1'b1, "R11", "set wins over clear", done_sts, 1);
    @(negedge clk); sts_clr = 1'b1;
    @(negedge clk); sts_clr = 1'b0;
    chk(done_sts == 1'b0, "R11", "later clear", done_sts, 0);
  endtask

  task automatic t_full();
    wr_desc(32'h600, OWN, 32'd2047, 32'h2000, 32'h610);
    wr_desc(32'h610, OWN, LAST | 32'd1, 32'h3000, 32'h620);
    wr_desc(32'h620, 32'h0, 32'h0, 32'h0, 32'h0);
    run_walk(32'h600, 1'b0);
    chk(cap_n == 2048, "R8", "exactly full accepted", cap_n, 2048);
    chk_bytes(0, 32'h2000, 2047, "R4");
    chk(cap[2047] == pat(32'h3000) && capl[2047] == 1'b1 && capl[2046] == 1'b0, "R6",
        "final byte", cap[2047], pat(32'h3000));
  endtask

  task automatic t_two_frames();
    wr_desc(32'h700, OWN, LAST | 32'd4, 32'h1300, 32'h710);
    wr_desc(32'h710, OWN, LAST | 32'h1000_0000 | 32'd4, 32'h1400, 32'h720);
    wr_desc(32'h720, 32'h0, 32'h0, 32'h0, 32'h0);
    run_walk(32'h700, 1'b0);
    chk(cap_n == 8, "R6", "two frames length", cap_n, 8);
    chk(capl[3] == 1'b1 && capl[7] == 1'b1 && capl[4] == 1'b0, "R6", "length restart",
        {capl[3], capl[4], capl[7]}, 5);
    chk_bytes(4, 32'h1400, 4, "R6");
    chk(capc[3] == 1'b0 && capc[7] == 1'b1, "R7", "per-frame csum", {capc[3], capc[7]}, 1);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG) begin
      nfail = nfail + 1;
      $display("FAIL watchdog R1 act=%0d exp=%0d", cyc, WDOG);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; base_wr = 1'b0; ctl_wr = 1'b0; ctl_start = 1'b0; ctl_dma_en = 1'b0;
    sts_clr = 1'b0; base_addr = '0; out_ready = 1'b1;
    for (int w = 0; w < 4096; w++)
      mem[w] = {pat(w*4+3), pat(w*4+2), pat(w*4+1), pat(w*4)};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_gather_stall();
    t_overflow();
    t_unowned();
    t_set_vs_clear();
    t_full();
    t_two_frames();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule